// File: doc/BRIEF.md
# Edge-Driven Event Counter with Compare Clear

This block counts transitions of an external, asynchronous event signal and divides that stream by a programmable amount. It does not count system clock cycles. A 2-bit field picks which transitions count: rising, falling, both, or none. Each counted transition advances a 16-bit up-counter. A compare value, written through a simple write port, sets the division ratio.

When the enable bit goes from low to high, the compare value is copied into an internal buffer and the counter is preset to all-ones. The first counted transition therefore brings the counter to zero. When the counter reaches the buffered value, the block raises an interrupt pulse one system clock wide. The next counted transition returns the counter to zero. A compare value of N gives one interrupt every N+1 counted transitions.

The event input is synchronized into the system clock domain, so transitions must be spaced several clock cycles apart. The live count can be read at any time.

Top module: `evc_event_counter`

## Requirements
- R1: After reset, the count output is 16'hFFFF and the interrupt output is low.
- R2: In the cycle after the enable bit rises, the counter is 16'hFFFF. The first valid transition after that brings it to 16'h0000.
- R3: The counter changes only when a valid transition of the event input is seen. With the enable bit high and a quiet input, the count holds, however many clock cycles pass. A transition shows on the count three clock cycles after it reaches the input.
- R4: The edge-select field is encoded as follows: 2'b00 counts nothing, 2'b01 counts rising transitions, 2'b10 counts falling transitions, and 2'b11 counts both.
- R5: The compare value is captured into the buffer only when counting starts. A compare write made while the counter runs has no effect until the next start.
- R6: With a buffered compare value N, the counter runs 0, 1, …, N. The valid transition that follows N returns it to 0. The interrupt fires once every N+1 valid transitions.
- R7: Each interrupt is high for exactly one system clock cycle. It is high in the same cycle the count output first shows the buffered compare value.
- R8: With a compare value of 0, every valid transition raises an interrupt, and the counter stays at 0.
- R9: While the enable bit is low, the counter holds 16'hFFFF, no transition is counted, and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | 1 | Asynchronous external event signal |
| edge_sel | input | 2 | Valid-transition select (00 none, 01 rise, 10 fall, 11 both) |
| cnt_en | input | 1 | Counting enable; a rising edge starts a run |
| cmp_wr | input | 1 | Write strobe for the compare value |
| cmp_wdata | input | 16 | Compare value to write |
| count | output | 16 | Live counter value |
| irq | output | 1 | Compare-match interrupt pulse |

## Verification
The bench sweeps every edge-select code against compare values 0 to 5, using pulse trains of fixed length. For each run it computes the expected final count and the expected number of interrupts from the number of valid transitions. An off-by-one preset or a late clear would show up as a wrong interrupt count or a wrong final count. So would a mis-decoded edge code.

A separate case writes a new compare value mid-run. A design that fed the live register to the match logic would divide by the wrong ratio. Idle-clock and disabled-input runs catch a counter that ticks on the clock or keeps running when disabled. A monitor checks the count at every interrupt cycle and counts the high cycles of the interrupt, so a stretched or misplaced pulse is caught.

// File: rtl/evc_pkg.sv
// Shared types for the edge-driven event counter.
package evc_pkg;

    // Valid-transition select; the code values are fixed by the port contract.
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

endpackage

// File: rtl/evc_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: the input is a slow level. Pulses shorter than a clock cycle may be lost.
module evc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/evc_edge_detect.sv
// Turns a synchronized level into a one-cycle step pulse, following the
// selected transition type.
// Assumes: lvl is already synchronous to clk.
module evc_edge_detect
    import evc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl,
    input  edge_sel_e sel,
    output logic      step
);
    logic prev_q;
    logic rise, fall;

    // Hold the previous sample of the level for the comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    // Qualify the raw transitions with the select code.
    always_comb begin
        unique case (sel)
            EDGE_RISE: step = rise;
            EDGE_FALL: step = fall;
            EDGE_BOTH: step = rise | fall;
            default:   step = 1'b0;
        endcase
    end
endmodule

// File: rtl/evc_count_core.sv
// Counter, compare buffer and match logic.
// A rising en starts a run: the counter is preset to all-ones and cmp_val is
// captured into the buffer. Each step advances the count; reaching the buffer
// value raises irq for one cycle, and the next step clears the count to zero.
// Assumes: a step in the start cycle is dropped.
module evc_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         step,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] count_q,
    output logic         irq_q
);
    localparam logic [W-1:0] ALL1 = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] buf_q;
    logic         en_q;
    logic         start;
    logic [W-1:0] nxt;
    logic         hit;

    assign start = en & ~en_q;

    // Next count: clear after a match, otherwise add one (all-ones wraps to zero).
    always_comb begin
        nxt = (count_q == buf_q) ? '0 : count_q + ONE;
        hit = (nxt == buf_q);
    end

    // Run control, buffer capture, counting and the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            count_q <= ALL1;
            buf_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            en_q  <= en;
            irq_q <= 1'b0;
            if (!en) begin
                count_q <= ALL1;
            end else if (start) begin
                count_q <= ALL1;
                buf_q   <= cmp_val;
            end else if (step) begin
                count_q <= nxt;
                irq_q   <= hit;
            end
        end
    end

    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count_q == ALL1) && (buf_q == $past(cmp_val)));
    assert_hold_no_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start && !step) |=> $stable(count_q));
    assert_buf_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start) |=> $stable(buf_q));
    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start && step && (count_q == buf_q)) |=> (count_q == '0));
    assert_irq_at_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (count_q == buf_q));
    assert_off_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count_q == ALL1) && !irq_q);
endmodule

// File: rtl/evc_event_counter.sv
// Top level: the compare register, the event synchronizer, the edge qualifier
// and the counting core.
// Assumes: event transitions are spaced at least three clock cycles apart.
module evc_event_counter
    import evc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_in,
    input  logic [1:0]       edge_sel,
    input  logic             cnt_en,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    logic [CNT_W-1:0] cmp_reg;
    logic             evt_sync;
    logic             evt_step;

    // Software-visible compare value; it reaches the core only at a start.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_reg <= '0;
        else if (cmp_wr) cmp_reg <= cmp_wdata;
    end

    evc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (evt_in),
        .q     (evt_sync)
    );

    evc_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (evt_sync),
        .sel   (edge_sel_e'(edge_sel)),
        .step  (evt_step)
    );

    evc_count_core #(.W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cnt_en),
        .step    (evt_step),
        .cmp_val (cmp_reg),
        .count_q (count),
        .irq_q   (irq)
    );

    assert_none_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == 2'b00) |-> !evt_step);
endmodule

// File: tb/evc_event_counter_bench.sv
`timescale 1ns/1ps
module evc_event_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_in = 1'b0;
    logic [1:0]  edge_sel = 2'b00;
    logic        cnt_en = 1'b0;
    logic        cmp_wr = 1'b0;
    logic [15:0] cmp_wdata = '0;
    logic [15:0] count;
    logic        irq;

    int tests = 0;
    int fails = 0;
    int irq_seen = 0;
    int cur_cmp = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evc_event_counter u_evc_event_counter (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .edge_sel(edge_sel),
        .cnt_en(cnt_en), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .count(count), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R7: count equals the compare value in every interrupt cycle; high cycles are counted.
    always @(negedge clk) begin
        if (mon_on && irq) begin
            irq_seen++;
            check("R7 count at irq", int'(count), cur_cmp);
        end
    end

    task automatic pulse();
        @(negedge clk) evt_in = 1'b1;
        repeat (4) @(negedge clk);
        evt_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_cmp(input int v);
        @(negedge clk) begin cmp_wr = 1'b1; cmp_wdata = 16'(v); end
        @(negedge clk) cmp_wr = 1'b0;
    endtask

    task automatic start_run(input int sel, input int n);
        cnt_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 idle value", int'(count), 16'hFFFF);
        write_cmp(n);
        edge_sel = 2'(sel);
        cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 preset", int'(count), 16'hFFFF);
        irq_seen = 0;
        cur_cmp = n;
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset count", int'(count), 16'hFFFF);
        check("R1 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R4, R6, R8: sweep the select codes against small compare values.
        for (int sel = 0; sel < 4; sel++) begin
            for (int n = 0; n < 6; n++) begin
                int e;
                start_run(sel, n);
                for (int p = 0; p < 7; p++) pulse();
                repeat (6) @(negedge clk);
                e = (sel == 0) ? 0 : (sel == 3) ? 14 : 7;
                check(n == 0 ? "R8 count" : "R6 R4 count", int'(count),
                      (e == 0) ? 16'hFFFF : (e - 1) % (n + 1));
                check(n == 0 ? "R8 irqs" : "R6 R4 irqs", irq_seen, e / (n + 1));
            end
        end

        // R3: no events, many clocks, the count holds.
        start_run(3, 2);
        repeat (50) @(negedge clk);
        check("R3 idle clocks", int'(count), 16'hFFFF);
        pulse();
        repeat (6) @(negedge clk);
        check("R3 one edge pair", int'(count), 1);

        // R5: a mid-run write is ignored until the next start.
        start_run(1, 3);
        pulse(); pulse();
        write_cmp(1);
        for (int p = 0; p < 10; p++) pulse();
        repeat (6) @(negedge clk);
        check("R5 count old cmp", int'(count), 3);
        check("R5 irqs old cmp", irq_seen, 3);
        cnt_en = 1'b0;
        repeat (2) @(negedge clk);
        cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        irq_seen = 0;
        cur_cmp = 1;
        for (int p = 0; p < 5; p++) pulse();
        repeat (6) @(negedge clk);
        check("R5 count new cmp", int'(count), 0);
        check("R5 irqs new cmp", irq_seen, 2);

        // R9: while disabled, events are not counted and no interrupt is raised.
        cnt_en = 1'b0;
        irq_seen = 0;
        for (int p = 0; p < 4; p++) pulse();
        repeat (6) @(negedge clk);
        check("R9 disabled count", int'(count), 16'hFFFF);
        check("R9 disabled irqs", irq_seen, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule